// File: doc/BRIEF.md
# Crossbar Gate Phase Sequencer

This block steps a small switch crossbar through the timed control-line phases that make it evaluate one logic gate. It keeps a logical model of every junction: four input-latch switches (one per horizontal line), two wired-AND columns of four junctions each, and one output switch. Each junction is either open or closed. A start strobe accepts a gate select and up to three input bits. The sequencer then drives a two-bit code on the input control line, on each AND column line and on the output control line for every phase. It updates the stored switch states at the end of each phase, and it reports the result and a done flag when the readout phase ends.

The gate type is chosen by the latching polarity of the inputs, by the polarity of the output readout, and by how many AND columns are evaluated. Three-input gates use one column. The two-input equivalence gates use two columns whose minterms are OR-ed one after the other into the output switch. Every phase lasts `PHASE_CYC` clock cycles.

Top module: `xbar_gate_seq`

## Requirements
- R1: The first phase after an accepted start drives positive (code 2) on the input line, on both AND column lines and on the output line, and opens every junction switch.
- R2: Control-line codes are float=0, ground=1, positive=2, negative=3. The codes for each phase are as follows. Latch: input negative, all others float. Transfer into column k: input ground, column k negative, all others float. Capture: input and output negative, columns float. Reopen column k: column k positive, all others float. Readout: output ground, all others float. Idle: all float. `ctl_and[1:0]` carries column 0 and `ctl_and[3:2]` carries column 1.
- R3: Gate select 0 (AND) latches inputs inverted, so an input of 0 closes its line switch. Lines 0..2 carry `in_bits[0..2]` into column 0. Capture closes the output only if every junction in the path is open, so the result is `in_bits[0] & in_bits[1] & in_bits[2]`. The sequence is clear, latch, transfer, capture, reopen, readout.
- R4: Gate select 1 (NAND) runs the AND sequence with the output read out inverted, giving the complement of the three-input AND.
- R5: Gate select 3 (NOR) latches inputs non-inverted, so an input of 1 closes its switch, and gives the three-input NOR. Gate select 2 (OR) adds the inverted readout and gives the three-input OR.
- R6: Gate select 4 (XNOR) places `in_bits[0]`, `in_bits[1]` on lines 0,1 and their complements on lines 2,3. Column 0 spans lines 0,1 and column 1 spans lines 2,3. The nine phases are clear, latch, transfer 0, capture, reopen 0, transfer 1, capture, reopen 1, readout. `in_bits[2]` is ignored.
- R7: The minterms are OR-ed in sequence. Once the first capture has closed the output switch, the second capture leaves it closed.
- R8: Gate select 5 (XOR) runs the XNOR sequence with inverted readout.
- R9: Gate selects 6 and 7 behave as AND.
- R10: Each phase lasts exactly `PHASE_CYC` cycles, and every control code is stable for the whole phase.
- R11: A start strobe while a sequence runs is ignored. It changes neither the sequence, its timing nor its result.
- R12: `done` rises with the result when the readout phase ends. `done` and `out_state` hold until the next accepted start, and `done` clears on that start.
- R13: After reset, all control lines float, `done` is 0 and `out_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| gate_sel | input | 3 | Gate type code |
| in_bits | input | 3 | Gate input bits |
| ctl_in | output | 2 | Input control-line code |
| ctl_and | output | 4 | AND column line codes, two bits per column |
| ctl_out | output | 2 | Output control-line code |
| out_state | output | 1 | Result read from the output switch |
| done | output | 1 | Sequence finished, result valid |

## Verification
The assertions assume that `start` is a clean synchronous strobe and that `gate_sel` and `in_bits` are valid in the cycle where a start is accepted. They do not require the inputs to hold after that cycle, because the block captures them. The bench drives every input at the falling clock edge and deliberately toggles `start`, `gate_sel` and `in_bits` in the middle of a sequence, so the checks cover the claim that the block ignores activity while busy. Every code of the gate select, including the two spare codes, is applied with input patterns that separate each gate's truth table.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_LATCH,
    PH_XFER,
    PH_CAPT,
    PH_REOPEN,
    PH_READ
  } phase_t;

  // control-line codes
  localparam logic [1:0] LN_FLOAT = 2'd0;
  localparam logic [1:0] LN_GND   = 2'd1;
  localparam logic [1:0] LN_POS   = 2'd2;
  localparam logic [1:0] LN_NEG   = 2'd3;

  // gate select codes
  localparam logic [2:0] G_AND  = 3'd0;
  localparam logic [2:0] G_NAND = 3'd1;
  localparam logic [2:0] G_OR   = 3'd2;
  localparam logic [2:0] G_NOR  = 3'd3;
  localparam logic [2:0] G_XNOR = 3'd4;
  localparam logic [2:0] G_XOR  = 3'd5;

  // crossbar geometry
  localparam int N_LINES = 4;
  localparam int N_COLS  = 2;
  localparam int CODE_W  = 2;

endpackage

// File: rtl/xbar_phase_fsm.sv
module xbar_phase_fsm
  import xbar_pkg::*;
#(
  parameter int PHASE_CYC = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   two_terms,
  output phase_t phase,
  output logic   term_idx,
  output logic   phase_end,
  output logic   accept,
  output logic   done
);

  localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_t           phase_d;
  logic             term_d;
  logic             done_d;

  assign accept    = start && (phase == PH_IDLE);
  assign phase_end = (phase != PH_IDLE) && (cnt_q == CNT_LAST);

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt_q;
    term_d  = term_idx;
    done_d  = done;
    if (accept) begin
      phase_d = PH_CLEAR;
      cnt_d   = '0;
      term_d  = 1'b0;
      done_d  = 1'b0;
    end else if (phase != PH_IDLE) begin
      if (phase_end) begin
        cnt_d = '0;
        case (phase)
          PH_CLEAR:  phase_d = PH_LATCH;
          PH_LATCH:  phase_d = PH_XFER;
          PH_XFER:   phase_d = PH_CAPT;
          PH_CAPT:   phase_d = PH_REOPEN;
          PH_REOPEN: begin
            if (two_terms && !term_idx) begin
              phase_d = PH_XFER;
              term_d  = 1'b1;
            end else begin
              phase_d = PH_READ;
            end
          end
          PH_READ: begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
          default: phase_d = PH_IDLE;
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt_q    <= '0;
      term_idx <= 1'b0;
      done     <= 1'b0;
    end else begin
      phase    <= phase_d;
      cnt_q    <= cnt_d;
      term_idx <= term_d;
      done     <= done_d;
    end
  end

endmodule

// File: rtl/xbar_switch_model.sv
module xbar_switch_model
  import xbar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       phase_end,
  input  phase_t     phase,
  input  logic       term_idx,
  input  logic [2:0] gate_sel,
  input  logic [2:0] in_bits,
  output logic       two_terms,
  output logic       out_state
);

  // 1 = closed junction, 0 = open junction
  logic [2:0]                           cfg_gate, cfg_bits;
  logic [N_LINES-1:0]                   sw_in_q, sw_in_d;
  logic [N_COLS-1:0][N_LINES-1:0]       sw_col_q, sw_col_d;
  logic [N_COLS-1:0][N_LINES-1:0]       col_mask;
  logic                                 sw_out_q, sw_out_d;
  logic                                 res_d;
  logic                                 inv_in, inv_out;
  logic [N_LINES-1:0]                   line_val, line_used;
  logic                                 path_open;

  // gate decode
  always_comb begin
    two_terms = (cfg_gate == G_XNOR) || (cfg_gate == G_XOR);
    inv_in    = !((cfg_gate == G_OR) || (cfg_gate == G_NOR));
    inv_out   = (cfg_gate == G_NAND) || (cfg_gate == G_OR) || (cfg_gate == G_XOR);
    if (two_terms) begin
      line_val  = {~cfg_bits[1], ~cfg_bits[0], cfg_bits[1], cfg_bits[0]};
      line_used = 4'b1111;
    end else begin
      line_val  = {1'b0, cfg_bits};
      line_used = 4'b0111;
    end
  end

  // column membership
  for (genvar c = 0; c < N_COLS; c++) begin : g_mask
    always_comb begin
      if (two_terms)
        col_mask[c] = N_LINES'(4'b0011 << (2 * c));
      else
        col_mask[c] = (c == 0) ? N_LINES'(4'b0111) : '0;
    end
  end

  assign path_open = ((sw_col_q[term_idx] & col_mask[term_idx]) == '0);

  always_comb begin
    sw_in_d  = sw_in_q;
    sw_col_d = sw_col_q;
    sw_out_d = sw_out_q;
    res_d    = out_state;
    if (phase_end) begin
      case (phase)
        PH_CLEAR: begin
          sw_in_d  = '0;
          sw_col_d = '0;
          sw_out_d = 1'b0;
        end
        PH_LATCH:  sw_in_d = (inv_in ? ~line_val : line_val) & line_used;
        PH_XFER:   sw_col_d[term_idx] = sw_in_q & col_mask[term_idx];
        PH_CAPT:   if (path_open) sw_out_d = 1'b1;
        PH_REOPEN: sw_col_d[term_idx] = '0;
        PH_READ:   res_d = sw_out_q ^ inv_out;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_gate  <= '0;
      cfg_bits  <= '0;
      sw_in_q   <= '0;
      sw_col_q  <= '0;
      sw_out_q  <= 1'b0;
      out_state <= 1'b0;
    end else begin
      if (accept) begin
        cfg_gate <= gate_sel;
        cfg_bits <= in_bits;
      end
      if (phase_end) begin
        sw_in_q   <= sw_in_d;
        sw_col_q  <= sw_col_d;
        sw_out_q  <= sw_out_d;
        out_state <= res_d;
      end
    end
  end

endmodule

// File: rtl/xbar_line_drive.sv
module xbar_line_drive
  import xbar_pkg::*;
(
  input  phase_t                     phase,
  input  logic                       term_idx,
  output logic [CODE_W-1:0]          ctl_in,
  output logic [N_COLS*CODE_W-1:0]   ctl_and,
  output logic [CODE_W-1:0]          ctl_out
);

  always_comb begin
    ctl_in  = LN_FLOAT;
    ctl_out = LN_FLOAT;
    case (phase)
      PH_CLEAR: begin ctl_in = LN_POS; ctl_out = LN_POS; end
      PH_LATCH: ctl_in = LN_NEG;
      PH_XFER:  ctl_in = LN_GND;
      PH_CAPT:  begin ctl_in = LN_NEG; ctl_out = LN_NEG; end
      PH_READ:  ctl_out = LN_GND;
      default:  ;
    endcase
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [CODE_W-1:0] code;
    always_comb begin
      code = LN_FLOAT;
      case (phase)
        PH_CLEAR:  code = LN_POS;
        PH_XFER:   if (term_idx == 1'(c)) code = LN_NEG;
        PH_REOPEN: if (term_idx == 1'(c)) code = LN_POS;
        default:   ;
      endcase
    end
    assign ctl_and[c*CODE_W +: CODE_W] = code;
  end

endmodule

// File: rtl/xbar_gate_seq.sv
module xbar_gate_seq
  import xbar_pkg::*;
#(
  parameter int PHASE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] gate_sel,
  input  logic [2:0] in_bits,
  output logic [1:0] ctl_in,
  output logic [3:0] ctl_and,
  output logic [1:0] ctl_out,
  output logic       out_state,
  output logic       done
);

  phase_t phase;
  logic   term_idx;
  logic   phase_end;
  logic   accept;
  logic   two_terms;

  xbar_phase_fsm #(.PHASE_CYC(PHASE_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .two_terms (two_terms),
    .phase     (phase),
    .term_idx  (term_idx),
    .phase_end (phase_end),
    .accept    (accept),
    .done      (done)
  );

  xbar_switch_model u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .phase_end (phase_end),
    .phase     (phase),
    .term_idx  (term_idx),
    .gate_sel  (gate_sel),
    .in_bits   (in_bits),
    .two_terms (two_terms),
    .out_state (out_state)
  );

  xbar_line_drive u_drv (
    .phase    (phase),
    .term_idx (term_idx),
    .ctl_in   (ctl_in),
    .ctl_and  (ctl_and),
    .ctl_out  (ctl_out)
  );

endmodule

// File: rtl/xbar_gate_seq_chk.sv
module xbar_gate_seq_chk
  import xbar_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input phase_t     phase,
  input logic       phase_end,
  input logic [1:0] ctl_in,
  input logic [3:0] ctl_and,
  input logic [1:0] ctl_out,
  input logic       out_state,
  input logic       done
);

  logic busy;
  logic [N_COLS-1:0] neg_cols;

  assign busy = (phase != PH_IDLE);

  always_comb begin
    for (int c = 0; c < N_COLS; c++)
      neg_cols[c] = (ctl_and[c*CODE_W +: CODE_W] == LN_NEG);
  end

  AST_FIRST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ctl_in == LN_POS && ctl_out == LN_POS && ctl_and == 4'b1010)); // R1

  AST_ONE_NEG_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(neg_cols)); // R2

  AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_end) |=> ($stable(ctl_in) && $stable(ctl_and) && $stable(ctl_out))); // R10

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_end) |=> ($stable(phase) && !done)); // R11

  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase == PH_READ && phase_end) |=> $stable(out_state)); // R12

endmodule

bind xbar_gate_seq xbar_gate_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .phase_end (phase_end),
  .ctl_in    (ctl_in),
  .ctl_and   (ctl_and),
  .ctl_out   (ctl_out),
  .out_state (out_state),
  .done      (done)
);

// File: tb/xbar_gate_seq_test.sv
`timescale 1ns/1ps
module xbar_gate_seq_test;

  localparam int P = 3;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [2:0] gate_sel;
  logic [2:0] in_bits;
  logic [1:0] ctl_in;
  logic [3:0] ctl_and;
  logic [1:0] ctl_out;
  logic       out_state;
  logic       done;

  int checks;
  int failures;

  xbar_gate_seq #(.PHASE_CYC(P)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .gate_sel  (gate_sel),
    .in_bits   (in_bits),
    .ctl_in    (ctl_in),
    .ctl_and   (ctl_and),
    .ctl_out   (ctl_out),
    .out_state (out_state),
    .done      (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {ctl_in, ctl_and, ctl_out} for phase k of a sequence
  function automatic logic [7:0] exp_ctl(input bit two, input int k);
    int ph;
    ph = k;
    if (!two && k >= 5) ph = 8;                // readout after one column
    case (ph)
      0: return {2'd2, 4'b1010, 2'd2};          // clear
      1: return {2'd3, 4'b0000, 2'd0};          // latch
      2: return {2'd1, 4'b0011, 2'd0};          // transfer col 0
      3: return {2'd3, 4'b0000, 2'd3};          // capture
      4: return {2'd0, 4'b0010, 2'd0};          // reopen col 0
      5: return {2'd1, 4'b1100, 2'd0};          // transfer col 1
      6: return {2'd3, 4'b0000, 2'd3};          // capture
      7: return {2'd0, 4'b1000, 2'd0};          // reopen col 1
      default: return {2'd0, 4'b0000, 2'd1};    // readout
    endcase
  endfunction

  // runs one gate; checks every cycle's codes, done timing and the result
  task automatic run_gate(input logic [2:0] g, input logic [2:0] b, input bit two,
                          input logic expv, input string tag, input bit glitch);
    int n;
    n = (two ? 9 : 6) * P;
    gate_sel = g;
    in_bits  = b;
    start    = 1'b1;
    for (int cyc = 1; cyc <= n + 1; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (glitch && cyc == 4) begin
        start    = 1'b1;                        // R11: strobe while busy
        gate_sel = ~g;
        in_bits  = ~b;
      end
      if (cyc <= n) begin
        check("R2 R10 control codes", {ctl_in, ctl_and, ctl_out}, exp_ctl(two, (cyc - 1) / P));
        check("R12 done low while running", {7'd0, done}, 8'd1 & 8'd0);
      end else begin
        check("R12 done after readout", {7'd0, done}, 8'd1);
        check(tag, {7'd0, out_state}, {7'd0, expv});
        check("R2 idle lines float", {ctl_in, ctl_and, ctl_out}, 8'd0);
      end
    end
    start = 1'b0;
  endtask

  task automatic t_reset;
    check("R13 reset done", {7'd0, done}, 8'd0);
    check("R13 reset out_state", {7'd0, out_state}, 8'd0);
    check("R13 reset lines float", {ctl_in, ctl_and, ctl_out}, 8'd0);
  endtask

  task automatic t_and_nand;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] b;
      b = 3'(v);
      run_gate(3'd0, b, 1'b0, &b, "R1 R3 AND result", 1'b0);
      run_gate(3'd1, b, 1'b0, ~(&b), "R4 NAND result", 1'b0);
    end
  endtask

  task automatic t_or_nor;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] b;
      b = 3'(v);
      run_gate(3'd3, b, 1'b0, ~(|b), "R5 NOR result", 1'b0);
      run_gate(3'd2, b, 1'b0, |b, "R5 OR result", 1'b0);
    end
  endtask

  task automatic t_xnor;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] b;
      b = 3'(v);
      // v=3: first minterm closes output (R7); v=0: second minterm closes it
      run_gate(3'd4, b, 1'b1, ~(b[0] ^ b[1]), "R6 R7 XNOR result", 1'b0);
    end
  endtask

  task automatic t_xor;
    for (int v = 0; v < 4; v++) begin
      logic [2:0] b;
      b = 3'(v) | 3'b100;
      run_gate(3'd5, b, 1'b1, b[0] ^ b[1], "R8 XOR result", 1'b0);
    end
  endtask

  task automatic t_spare_codes;
    run_gate(3'd6, 3'b111, 1'b0, 1'b1, "R9 code 6 as AND", 1'b0);
    run_gate(3'd6, 3'b101, 1'b0, 1'b0, "R9 code 6 as AND", 1'b0);
    run_gate(3'd7, 3'b111, 1'b0, 1'b1, "R9 code 7 as AND", 1'b0);
    run_gate(3'd7, 3'b011, 1'b0, 1'b0, "R9 code 7 as AND", 1'b0);
  endtask

  task automatic t_start_ignored;
    run_gate(3'd0, 3'b111, 1'b0, 1'b1, "R11 AND ignores busy start", 1'b1);
    run_gate(3'd4, 3'b010, 1'b1, 1'b0, "R11 XNOR ignores busy start", 1'b1);
  endtask

  task automatic t_done_hold;
    run_gate(3'd1, 3'b011, 1'b0, 1'b1, "R4 NAND result", 1'b0);
    gate_sel = 3'd0;
    in_bits  = 3'b111;
    repeat (12) @(negedge clk);
    check("R12 done holds", {7'd0, done}, 8'd1);
    check("R12 out_state holds", {7'd0, out_state}, 8'd1);
    run_gate(3'd0, 3'b111, 1'b0, 1'b1, "R12 next start clears done", 1'b0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    gate_sel = 3'd0;
    in_bits  = 3'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_and_nand();
    t_or_nor();
    t_xnor();
    t_xor();
    t_spare_codes();
    t_start_ignored();
    t_done_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule